// File: doc/BRIEF.md
# Residual Timestamp Receive Queue

This block is a small first-in first-out store, one per port. It holds residual timestamp values on their way to a clock-recovery PLL. Each value is 4 bits by default, and the queue is 8 entries deep. Values arrive from one of two sources. The first is the received stream. The second is the port's own local timestamp generator, which serves as a loopback path for testing. A write gate drops every arriving value while timestamp use is switched off or while the port is powered down.

The PLL is held off when the block comes out of reset. It is released only after a set number of values have been stored, five by default. Until then the block reports a free-running status. The queue is normally drained by pop strobes from the PLL side, at the recovered service rate. Because the fill rate and the drain rate need not match, the block flags overflow and underflow with sticky bits. When the test enable bit is set, a register read strobe takes over the pop, so a processor can read out entries one at a time. Powering the port down empties the queue and restarts the start-up count.

Top module: `rts_rx_queue`

## Requirements
- R1: After reset `pll_en` is 0. It becomes 1 in the cycle after the fifth stored value, and no value stored before that cycle makes it 1.
- R2: `free_run` is 1 whenever `pll_en` is 0, and it is 0 once the PLL has been released.
- R3: No value is stored while `cfg_use_rts` is 0 or `cfg_pwr_down` is 1.
- R4: While `cfg_test_en` is 1, a `reg_rd` strobe pops the oldest entry and shows it on `pop_data` in the next cycle. In that mode `pll_pop` is ignored.
- R5: While `cfg_gen_loop` is 1, values come from `gen_wr`/`gen_data` and `rx_wr`/`rx_data` is ignored. While it is 0, the opposite holds.
- R6: Entries leave in the order they were stored. A `pll_pop` strobe is honoured only while `pll_en` is 1, and the popped value appears on `pop_data` one cycle after the strobe.
- R7: A write that finds the queue full with no pop in the same cycle is discarded and sets `ovf_flag`. A write and a pop in the same cycle on a full queue are both accepted.
- R8: A pop on an empty queue leaves `pop_data` unchanged and sets `unf_flag`.
- R9: `ovf_flag` and `unf_flag` stay set until a `reg_clr` strobe, which clears them in the next cycle. If a new event occurs in the same cycle as the strobe, the flag stays set.
- R10: A cycle with `cfg_pwr_down` at 1 empties the queue, returns `pll_en` to 0 and restarts the count of R1 from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_use_rts | input | 1 | The PLL uses timestamp values |
| cfg_pwr_down | input | 1 | Port power-down |
| cfg_gen_loop | input | 1 | Take values from the local generator |
| cfg_test_en | input | 1 | Processor test-read mode |
| rx_wr | input | 1 | Received value strobe |
| rx_data | input | DATA_W | Received value |
| gen_wr | input | 1 | Local generator value strobe |
| gen_data | input | DATA_W | Local generator value |
| pll_pop | input | 1 | Pop strobe from the PLL side |
| reg_rd | input | 1 | Processor read of the test output register |
| reg_clr | input | 1 | Processor write that clears the sticky flags |
| pop_data | output | DATA_W | Last popped value |
| pll_en | output | 1 | PLL release |
| free_run | output | 1 | PLL is free running |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
The checker tests a set of rules on every cycle:
- The fill level never exceeds the queue depth, and nothing is stored while the write gate is closed.
- Every overflowing write or empty pop sets its flag, and an empty pop holds the output.
- Power-down empties the queue and holds off the PLL.
- The PLL can only be released in a cycle that stores a value.

Only the bench scenarios can show the rest:
- the order in which data leaves the queue,
- the exact fifth-value release point,
- that a value discarded on overflow never reappears,
- the hand-over between the PLL pop and the test read,
- the choice between the received and the generated source.

// File: rtl/rts_rxq_pkg.sv
package rts_rxq_pkg;
   localparam int unsigned DEF_DATA_W = 4;
   localparam int unsigned DEF_DEPTH  = 8;
   localparam int unsigned DEF_START  = 5;

   typedef enum logic {
      SRC_RX  = 1'b0,
      SRC_GEN = 1'b1
   } rts_src_e;

   typedef enum logic {
      POP_PLL  = 1'b0,
      POP_TEST = 1'b1
   } rts_pop_e;
endpackage

// File: rtl/rts_rxq_store.sv
module rts_rxq_store #(
   parameter int unsigned DATA_W = 4,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp, rp, wp_nx, rp_nx;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         unique case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign head  = mem[rp];
   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);
endmodule

// File: rtl/rts_rxq_gate.sv
module rts_rxq_gate #(
   parameter int unsigned START_CNT = 5,
   localparam int unsigned CNT_W = $clog2(START_CNT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic stored,
   output logic release_o,
   output logic free_run
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt <= '0;
      else if (restart)                          cnt <= '0;
      else if (stored && cnt != CNT_W'(START_CNT)) cnt <= cnt + 1'b1;
   end

   assign release_o = (cnt == CNT_W'(START_CNT));
   assign free_run  = ~release_o;
endmodule

// File: rtl/rts_rxq_sticky.sv
module rts_rxq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/rts_rx_queue.sv
module rts_rx_queue
   import rts_rxq_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned DEPTH     = DEF_DEPTH,
   parameter int unsigned START_CNT = DEF_START,
   localparam int unsigned LVL_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_use_rts,
   input  logic              cfg_pwr_down,
   input  logic              cfg_gen_loop,
   input  logic              cfg_test_en,
   input  logic              rx_wr,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              gen_wr,
   input  logic [DATA_W-1:0] gen_data,
   input  logic              pll_pop,
   input  logic              reg_rd,
   input  logic              reg_clr,
   output logic [DATA_W-1:0] pop_data,
   output logic              pll_en,
   output logic              free_run,
   output logic              ovf_flag,
   output logic              unf_flag
);
   initial begin
      assert (DATA_W >= 1) else $fatal(1, "DATA_W must be at least 1");
      assert (DEPTH >= 2) else $fatal(1, "DEPTH must be at least 2");
      assert (START_CNT >= 1 && START_CNT <= DEPTH)
         else $fatal(1, "START_CNT must lie in 1..DEPTH");
   end

   rts_src_e          src_sel;
   rts_pop_e          pop_sel;
   logic              src_wr, wr_req, pop_req, push_ok, pop_ok;
   logic              ovf_set, unf_set;
   logic [DATA_W-1:0] src_data, head;
   logic [LVL_W-1:0]  lvl;
   logic              full, empty;

   assign src_sel = cfg_gen_loop ? SRC_GEN : SRC_RX;
   assign pop_sel = cfg_test_en  ? POP_TEST : POP_PLL;

   always_comb begin
      unique case (src_sel)
         SRC_GEN: begin src_wr = gen_wr; src_data = gen_data; end
         default: begin src_wr = rx_wr;  src_data = rx_data;  end
      endcase
      unique case (pop_sel)
         POP_TEST: pop_req = reg_rd;
         default:  pop_req = pll_pop & pll_en;
      endcase
   end

   assign wr_req  = src_wr & cfg_use_rts & ~cfg_pwr_down;
   assign pop_ok  = pop_req & ~empty & ~cfg_pwr_down;
   assign push_ok = wr_req & (~full | pop_ok);
   assign ovf_set = wr_req & full & ~pop_ok;
   assign unf_set = pop_req & empty & ~cfg_pwr_down;

   rts_rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
      .clk(clk), .rst_n(rst_n), .flush(cfg_pwr_down),
      .push(push_ok), .push_data(src_data), .pop(pop_ok),
      .head(head), .level(lvl), .full(full), .empty(empty)
   );

   rts_rxq_gate #(.START_CNT(START_CNT)) i_gate (
      .clk(clk), .rst_n(rst_n), .restart(cfg_pwr_down), .stored(push_ok),
      .release_o(pll_en), .free_run(free_run)
   );

   logic [1:0] flag_set, flag_q;
   assign flag_set = {unf_set, ovf_set};

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_flag
         rts_rxq_sticky i_flag (
            .clk(clk), .rst_n(rst_n), .set(flag_set[gi]), .clr(reg_clr),
            .flag(flag_q[gi])
         );
      end
   endgenerate

   assign ovf_flag = flag_q[0];
   assign unf_flag = flag_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pop_data <= '0;
      else if (pop_ok) pop_data <= head;
   end
endmodule

// File: rtl/rts_rxq_chk.sv
module rts_rxq_chk #(
   parameter int unsigned DATA_W = 4,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_use_rts,
   input logic              cfg_pwr_down,
   input logic              cfg_test_en,
   input logic              reg_rd,
   input logic              reg_clr,
   input logic              pll_pop,
   input logic              pll_en,
   input logic              push_ok,
   input logic              wr_req,
   input logic              pop_ok,
   input logic [LVL_W-1:0]  lvl,
   input logic [DATA_W-1:0] pop_data,
   input logic              ovf_flag,
   input logic              unf_flag
);
   logic pop_try;
   assign pop_try = cfg_test_en ? reg_rd : (pll_pop & pll_en);

   p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pll_en && !push_ok) |=> !pll_en);

   p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_use_rts || cfg_pwr_down) |=> (lvl <= $past(lvl)));

   p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lvl <= LVL_W'(DEPTH));

   p_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && lvl == LVL_W'(DEPTH) && !pop_ok) |=> ovf_flag);

   p_unf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_try && lvl == '0 && !cfg_pwr_down) |=> (unf_flag && $stable(pop_data)));

   p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_clr && !(pop_try && lvl == '0 && !cfg_pwr_down)) |=> !unf_flag);

   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pwr_down |=> (lvl == '0 && !pll_en));
endmodule

bind rts_rx_queue rts_rxq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_use_rts(cfg_use_rts),
   .cfg_pwr_down(cfg_pwr_down), .cfg_test_en(cfg_test_en), .reg_rd(reg_rd),
   .reg_clr(reg_clr), .pll_pop(pll_pop), .pll_en(pll_en), .push_ok(push_ok),
   .wr_req(wr_req), .pop_ok(pop_ok), .lvl(lvl), .pop_data(pop_data),
   .ovf_flag(ovf_flag), .unf_flag(unf_flag)
);

// File: tb/test_rts_rx_queue.sv
`timescale 1ns/1ps
module test_rts_rx_queue;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic use_rts, pd, gl, te, rxw, gw, pp, rd, clr;
   logic [3:0] rxd, gd;
   logic [3:0] pop_data;
   logic pll_en, free_run, ovf_flag, unf_flag;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rts_rx_queue i_rts_rx_queue (
      .clk(clk), .rst_n(rst_n), .cfg_use_rts(use_rts), .cfg_pwr_down(pd),
      .cfg_gen_loop(gl), .cfg_test_en(te), .rx_wr(rxw), .rx_data(rxd),
      .gen_wr(gw), .gen_data(gd), .pll_pop(pp), .reg_rd(rd), .reg_clr(clr),
      .pop_data(pop_data), .pll_en(pll_en), .free_run(free_run),
      .ovf_flag(ovf_flag), .unf_flag(unf_flag)
   );

   typedef struct packed {
      logic u, p, g, t, rw; logic [3:0] rdat; logic gwr; logic [3:0] gdat;
      logic pop, rrd, cl; logic [3:0] e_dat; logic e_en, e_ovf, e_unf;
   } vec_t;

   // Rows 0-1: R3 gate. 2-6: R1 count, R5 source, R6 pop ignored before release.
   // 7-12: R6 order, R4 test read. 13-16: R8 underflow, R9 clear.
   localparam int NV = 17;
   localparam vec_t V [NV] = '{
      '{1'b0,1'b0,1'b0,1'b0,1'b1,4'hA,1'b0,4'h0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0},
      '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hB,1'b0,4'h0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h1,1'b0,4'h0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h2,1'b0,4'h0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h3,1'b0,4'h0,1'b1,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0},
      '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,4'h4,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0},
      '{1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,4'h5,1'b0,1'b0,1'b0, 4'h0,1'b1,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1,1'b0,1'b0, 4'h1,1'b1,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1,1'b0,1'b0, 4'h2,1'b1,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,4'h0,1'b1,1'b0,1'b0, 4'h2,1'b1,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0,1'b1,1'b0, 4'h3,1'b1,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0,1'b1,1'b0, 4'h4,1'b1,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1,1'b0,1'b0, 4'h5,1'b1,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1,1'b0,1'b0, 4'h5,1'b1,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0,1'b0,1'b1, 4'h5,1'b1,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1,1'b0,1'b1, 4'h5,1'b1,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0,1'b0,1'b1, 4'h5,1'b1,1'b0,1'b0}
   };

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic idle();
      rxw = 0; gw = 0; pp = 0; rd = 0; clr = 0; rxd = '0; gd = '0;
   endtask

   task automatic step();
      @(posedge clk); #1;
      @(negedge clk);
      idle();
   endtask

   task automatic wr(input logic [3:0] d);
      rxw = 1; rxd = d; step();
   endtask

   task automatic pop_pll(input logic [3:0] e, input string req);
      pp = 1; step(); chk(req, pop_data, e);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      use_rts = 1; pd = 0; gl = 0; te = 0; idle();
      repeat (3) @(negedge clk);
      // R1 R2 reset state
      chk("R1 reset pll_en", pll_en, 0);
      chk("R2 reset free_run", free_run, 1);
      chk("R9 reset flags", {ovf_flag, unf_flag}, 0);
      rst_n = 1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         use_rts = V[i].u; pd = V[i].p; gl = V[i].g; te = V[i].t;
         rxw = V[i].rw; rxd = V[i].rdat; gw = V[i].gwr; gd = V[i].gdat;
         pp = V[i].pop; rd = V[i].rrd; clr = V[i].cl;
         step();
         chk($sformatf("R6 row %0d pop_data", i), pop_data, V[i].e_dat);
         chk($sformatf("R1 row %0d pll_en", i), pll_en, V[i].e_en);
         chk($sformatf("R2 row %0d free_run", i), free_run, !V[i].e_en);
         chk($sformatf("R7 row %0d ovf", i), ovf_flag, V[i].e_ovf);
         chk($sformatf("R8 row %0d unf", i), unf_flag, V[i].e_unf);
      end
      use_rts = 1; pd = 0; gl = 0; te = 0;

      // R7 overflow: ninth write discarded
      for (int i = 0; i < 8; i++) wr(4'(8 + i));
      chk("R7 no ovf at exactly full", ovf_flag, 0);
      wr(4'h0);
      chk("R7 ovf on full write", ovf_flag, 1);
      for (int i = 0; i < 8; i++) pop_pll(4'(8 + i), "R7 order after overflow");
      pp = 1; step();
      chk("R7 discarded value absent", pop_data, 4'hF);
      chk("R8 unf after drain", unf_flag, 1);
      clr = 1; step();
      chk("R9 clear both flags", {ovf_flag, unf_flag}, 0);

      // R7 full queue with push and pop in the same cycle
      for (int i = 0; i < 8; i++) wr(4'(i));
      rxw = 1; rxd = 4'h9; pp = 1; step();
      chk("R7 push+pop on full", pop_data, 0);
      chk("R7 no ovf on push+pop", ovf_flag, 0);
      for (int i = 1; i < 8; i++) pop_pll(4'(i), "R6 order");
      pop_pll(4'h9, "R7 simultaneous push kept");

      // R10 power-down flush and restart
      wr(4'h3); wr(4'h4);
      pd = 1; step(); pd = 0;
      chk("R10 pll_en after pd", pll_en, 0);
      chk("R2 free_run after pd", free_run, 1);
      te = 1; rd = 1; step(); te = 0;
      chk("R10 queue flushed (unf)", unf_flag, 1);
      chk("R10 flushed pop holds", pop_data, 4'h9);
      clr = 1; step();
      for (int i = 0; i < 4; i++) wr(4'(i + 1));
      chk("R1 four values not enough", pll_en, 0);
      gl = 1; rxw = 1; rxd = 4'h7; step();
      chk("R5 rx ignored in loop mode", pll_en, 0);
      gw = 1; gd = 4'hC; step(); gl = 0;
      chk("R1 fifth value releases", pll_en, 1);
      for (int i = 0; i < 4; i++) pop_pll(4'(i + 1), "R10 order after restart");
      pop_pll(4'hC, "R5 generated value stored");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule